// File: doc/BRIEF.md
# Interlaced Field Parity Detector

This block tells the rest of a video timing path whether the field now being received from an interlaced composite-sync stream is odd or even. It makes the call exactly once per field, when the vertical sync strobe from an upstream vertical detector goes active. At that moment it looks at where the free-running horizontal line counter stands. In an odd field the first broad vertical pulse starts together with a line. In an even field it starts roughly half a line later. The upstream detector has a fixed delay, so the block first winds the sampled position back by a parameterised number of clock cycles. It then classifies the result as near the start of the line or near mid-line.

Because the decision is taken only at the start of the vertical interval, the equalizing pulses that come before it cannot disturb the result, even when they are noisy or there are too many of them. The result stays registered for the whole field. A vertical strobe edge is taken only while the sampled composite sync is also low, because a genuine vertical interval always begins inside a broad pulse. A companion valid flag shows whether any decision has been made since reset.

All inputs are plain level signals sampled on the clock, and both outputs are plain status levels. There is no streaming interface, so no back-pressure rules apply.

Top module: `field_parity_det`

## Requirements
- R1: After reset, and until the first accepted vertical edge, `field_odd` is 0 and `field_valid` is 0.
- R2: The outputs change only in the clock cycle that follows an accepted vertical edge. At every other time they hold their values, including while `vsync_n` stays low.
- R3: If the compensated position at an accepted edge is below LINE_LEN/4, or at or above LINE_LEN - LINE_LEN/4, then `field_odd` becomes 1.
- R4: If the compensated position at an accepted edge lies from LINE_LEN/4 up to LINE_LEN - LINE_LEN/4 - 1, then `field_odd` becomes 0.
- R5: The compensated position is (`line_pos` - VS_LATENCY) modulo LINE_LEN, where `line_pos` is the value sampled in the edge cycle. It wraps correctly across the start of the line.
- R6: An accepted vertical edge is a clock cycle in which `vsync_n` is 0, its value in the previous cycle was 1 (taken as 1 during reset), and `csync_n` is 0. A falling edge of `vsync_n` that occurs while `csync_n` is 1 is ignored.
- R7: Composite sync pulses and glitches that arrive while `vsync_n` is high, including an extra equalizing pulse, leave `field_odd` and `field_valid` unchanged.
- R8: `field_valid` goes to 1 with the first accepted edge and stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csync_n | input | 1 | Sampled composite sync, low during sync pulses |
| vsync_n | input | 1 | Vertical sync strobe from the vertical detector, low while active |
| line_pos | input | $clog2(LINE_LEN) | Horizontal line position, from 0 to LINE_LEN-1 |
| field_odd | output | 1 | 1 for an odd field, 0 for an even field |
| field_valid | output | 1 | 1 once a field decision has been made |

## Verification
On every cycle, the assertions check that the outputs hold when no accepted edge occurs. They also check that the valid flag never falls or rises on its own, that the parity is 0 whenever the flag is 0, and that each accepted edge produces the class given by the compensated position. Only the bench's scenarios can show the full picture: fields of opposite parity following each other, exact quarter-line boundaries, latency wrap-around, and decisions that survive noisy or extra equalizing pulses and unqualified strobe edges.

// File: rtl/field_parity_pkg.sv
package field_parity_pkg;

  // Where the compensated start of the vertical interval falls within a line.
  typedef enum logic [0:0] {
    PHASE_MID  = 1'b0,  // near mid-line: even field
    PHASE_EDGE = 1'b1   // near the line start: odd field
  } line_phase_e;

  // Decision carried from the classifier to the output register.
  typedef struct packed {
    logic        take;   // accepted vertical edge this cycle
    line_phase_e phase;  // classified phase at that edge
  } field_decision_t;

  function automatic int pos_width(input int len);
    return (len < 2) ? 1 : $clog2(len);
  endfunction

endpackage

// File: rtl/fp_edge_qual.sv
// Qualifies vertical strobe edges: a high-to-low step of vsync_n that
// happens while composite sync is low (R6).
module fp_edge_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic csync_n,
  input  logic vsync_n,
  output logic accept_o
);
  logic vs_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vs_prev <= 1'b1;
    else        vs_prev <= vsync_n;
  end

  always_comb accept_o = vs_prev & ~vsync_n & ~csync_n;
endmodule

// File: rtl/fp_phase_comp.sv
// Removes the vertical detector's fixed delay from the sampled line position (R5).
module fp_phase_comp #(
  parameter int LINE_LEN   = 858,
  parameter int VS_LATENCY = 24,
  localparam int POS_W     = field_parity_pkg::pos_width(LINE_LEN)
) (
  input  logic [POS_W-1:0] pos_i,
  output logic [POS_W-1:0] pos_o
);
  localparam int LAT_MOD = VS_LATENCY % LINE_LEN;

  generate
    if (LAT_MOD == 0) begin : g_pass
      always_comb pos_o = pos_i;
    end else begin : g_sub
      localparam logic [POS_W:0] LAT_W = (POS_W+1)'(LAT_MOD);
      localparam logic [POS_W:0] LEN_W = (POS_W+1)'(LINE_LEN);
      logic [POS_W:0] ext;
      always_comb begin
        ext = {1'b0, pos_i};
        if (ext >= LAT_W) pos_o = POS_W'(ext - LAT_W);
        else              pos_o = POS_W'(ext + LEN_W - LAT_W);
      end
    end
  endgenerate
endmodule

// File: rtl/fp_phase_class.sv
// Sorts a compensated position into line-edge (odd) or mid-line (even) (R3, R4).
module fp_phase_class #(
  parameter int LINE_LEN = 858,
  localparam int POS_W   = field_parity_pkg::pos_width(LINE_LEN)
) (
  input  logic [POS_W-1:0]                pos_i,
  output field_parity_pkg::line_phase_e   phase_o
);
  import field_parity_pkg::*;
  localparam int QUART = LINE_LEN / 4;
  localparam logic [POS_W-1:0] LO_LIM = POS_W'(QUART);
  localparam logic [POS_W-1:0] HI_LIM = POS_W'(LINE_LEN - QUART);

  always_comb begin
    if (pos_i < LO_LIM || pos_i >= HI_LIM) phase_o = PHASE_EDGE;
    else                                   phase_o = PHASE_MID;
  end
endmodule

// File: rtl/fp_field_reg.sv
// Holds the field decision for the whole field (R1, R2, R8).
module fp_field_reg (
  input  logic                              clk,
  input  logic                              rst_n,
  input  field_parity_pkg::field_decision_t dec_i,
  output logic                              odd_o,
  output logic                              valid_o
);
  import field_parity_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odd_o   <= 1'b0;
      valid_o <= 1'b0;
    end else if (dec_i.take) begin
      odd_o   <= (dec_i.phase == PHASE_EDGE);
      valid_o <= 1'b1;
    end
  end
endmodule

// File: rtl/field_parity_det.sv
module field_parity_det #(
  parameter int LINE_LEN   = 858,
  parameter int VS_LATENCY = 24,
  localparam int POS_W     = field_parity_pkg::pos_width(LINE_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csync_n,
  input  logic             vsync_n,
  input  logic [POS_W-1:0] line_pos,
  output logic             field_odd,
  output logic             field_valid
);
  import field_parity_pkg::*;

  logic            accept;
  logic [POS_W-1:0] comp_pos;
  line_phase_e     phase;
  field_decision_t dec;

  fp_edge_qual u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .csync_n  (csync_n),
    .vsync_n  (vsync_n),
    .accept_o (accept)
  );

  fp_phase_comp #(.LINE_LEN(LINE_LEN), .VS_LATENCY(VS_LATENCY)) u_comp (
    .pos_i (line_pos),
    .pos_o (comp_pos)
  );

  fp_phase_class #(.LINE_LEN(LINE_LEN)) u_class (
    .pos_i   (comp_pos),
    .phase_o (phase)
  );

  always_comb begin
    dec.take  = accept;
    dec.phase = phase;
  end

  fp_field_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .dec_i   (dec),
    .odd_o   (field_odd),
    .valid_o (field_valid)
  );
endmodule

// File: rtl/field_parity_chk.sv
module field_parity_chk #(
  parameter int LINE_LEN   = 858,
  parameter int VS_LATENCY = 24,
  localparam int POS_W     = field_parity_pkg::pos_width(LINE_LEN)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             csync_n,
  input logic             vsync_n,
  input logic [POS_W-1:0] line_pos,
  input logic             field_odd,
  input logic             field_valid
);
  logic chk_vs_prev;
  logic chk_acc;
  logic chk_edge_class;
  int   chk_comp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_vs_prev <= 1'b1;
    else        chk_vs_prev <= vsync_n;
  end

  always_comb begin
    chk_acc  = chk_vs_prev && !vsync_n && !csync_n;
    chk_comp = (int'(line_pos) + LINE_LEN - (VS_LATENCY % LINE_LEN)) % LINE_LEN;
    chk_edge_class = (chk_comp < LINE_LEN / 4) || (chk_comp >= LINE_LEN - LINE_LEN / 4);
  end

  a_r1_invalid_is_even: assert property (@(posedge clk) disable iff (!rst_n)
    !field_valid |-> !field_odd);

  a_r2_hold_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_acc |=> ($stable(field_odd) && $stable(field_valid)));

  a_r8_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    field_valid |=> field_valid);

  a_r6_valid_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(field_valid) |-> $past(chk_acc));

  a_r3_edge_is_odd: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_acc && chk_edge_class) |=> (field_odd && field_valid));

  a_r4_mid_is_even: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_acc && !chk_edge_class) |=> (!field_odd && field_valid));
endmodule

bind field_parity_det field_parity_chk #(
  .LINE_LEN   (LINE_LEN),
  .VS_LATENCY (VS_LATENCY)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .csync_n     (csync_n),
  .vsync_n     (vsync_n),
  .line_pos    (line_pos),
  .field_odd   (field_odd),
  .field_valid (field_valid)
);

// File: tb/tb_field_parity_det.sv
`timescale 1ns/1ps
module tb_field_parity_det;
  localparam int L   = 64;
  localparam int LAT = 5;
  localparam int PW  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csync_n = 1'b1;
  logic vsync_n = 1'b1;
  logic [PW-1:0] line_pos = '0;
  logic field_odd, field_valid;

  int tests = 0;
  int fails = 0;
  int pos = 0;
  int cycles = 0;
  bit exp_odd = 1'b0;
  bit exp_valid = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  field_parity_det #(.LINE_LEN(L), .VS_LATENCY(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .csync_n(csync_n), .vsync_n(vsync_n),
    .line_pos(line_pos), .field_odd(field_odd), .field_valid(field_valid)
  );

  function automatic bit is_odd_start(input int s);
    return (s < L / 4) || (s >= L - L / 4);
  endfunction

  task automatic step(input bit cs, input bit vs);
    @(negedge clk);
    csync_n  = cs;
    vsync_n  = vs;
    line_pos = PW'(pos);
    pos = (pos + 1) % L;
  endtask

  task automatic check(input bit got, input bit exp, input string req, input string what);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic check_both(input string req, input string what);
    check(field_odd, exp_odd, req, {what, " odd"});
    check(field_valid, exp_valid, req, {what, " valid"});
  endtask

  // One field: equalizing pulses, broad pulses starting at line phase 'start',
  // vertical strobe LAT cycles after the broad pulse starts.
  task automatic do_field(input int start, input int n_pre, input bit noise,
                          input bit qual, input string req);
    bit cs;
    for (int i = 0; i < n_pre; i++) begin
      for (int c = 0; c < L / 2; c++) begin
        cs = (c < 2) ? 1'b0 : 1'b1;
        if (noise && ($urandom % 7 == 0)) cs = ~cs;
        step(cs, 1'b1);
      end
    end
    check_both("R7", "after equalizing pulses");
    while (pos != start) step(1'b1, 1'b1);
    for (int c = 0; c < 2 * L; c++) begin
      cs = ((c % (L / 2)) < (L / 2 - 4)) ? 1'b0 : 1'b1;
      if (c == LAT && !qual) cs = 1'b1;
      step(cs, (c >= LAT) ? 1'b0 : 1'b1);
      if (c == LAT + 1) begin
        if (qual) begin
          exp_odd   = is_odd_start(start);
          exp_valid = 1'b1;
        end
        check_both(qual ? req : "R6", $sformatf("start %0d", start));
      end
    end
    for (int c = 0; c < L; c++) step((c % (L / 2)) < 2 ? 1'b0 : 1'b1, 1'b1);
    check_both("R2", $sformatf("hold after field start %0d", start));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4982));
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1);
    check_both("R1", "in reset");
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < 8; i++) step(1'b1, 1'b1);
    check_both("R1", "after reset");
    // unqualified strobe before any decision: still invalid (R1, R6)
    do_field(0, 6, 1'b0, 1'b0, "R6");
    check_both("R1", "no decision yet");
    // directed boundaries
    do_field(0,  6, 1'b0, 1'b1, "R3");
    do_field(32, 6, 1'b0, 1'b1, "R4");
    do_field(15, 6, 1'b0, 1'b1, "R3");
    do_field(16, 6, 1'b0, 1'b1, "R4");
    do_field(48, 6, 1'b0, 1'b1, "R3");
    do_field(47, 6, 1'b0, 1'b1, "R4");
    do_field(63, 6, 1'b0, 1'b1, "R3");
    // latency compensation: wrap and class changed by the shift
    do_field(62, 6, 1'b0, 1'b1, "R5");
    do_field(29, 6, 1'b0, 1'b1, "R5");
    do_field(13, 6, 1'b0, 1'b1, "R5");
    // extra noisy equalizing pulse, then an unqualified even-phase strobe
    do_field(32, 7, 1'b1, 1'b1, "R7");
    do_field(4,  7, 1'b1, 1'b1, "R7");
    do_field(32, 6, 1'b0, 1'b0, "R6");
    check(field_valid, 1'b1, "R8", "valid sticky");
    // random fields
    for (int k = 0; k < 24; k++) begin
      int s;
      s = int'($urandom % L);
      do_field(s, 5 + int'($urandom % 4), 1'b1, ($urandom % 5) != 0,
               is_odd_start(s) ? "R3" : "R4");
    end
    check(field_valid, 1'b1, "R8", "valid after random run");
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    exp_odd = 1'b0;
    exp_valid = 1'b0;
    check_both("R1", "re-reset");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule